// File: doc/BRIEF.md
# Barrel Shifter with Carry Out

This block is the operand shifter of a simple integer datapath. It takes one 32-bit operand and moves it left, right or round in a single combinational pass. It also returns the last bit that left the word, so that a later flag stage can take it up as the shifter carry. It supports four shift kinds. The amount may come from an instruction field or from a general register, and the two sources follow different rules.

An immediate amount is a 5-bit field, so zero in that field is free to carry a second meaning. For a left shift it means no shift at all. For either right shift it means a shift by the full word width. For a rotate it means a one-bit rotate through the incoming carry. A register amount uses the 8-bit low byte of the register. In that case zero always means no shift, and amounts at or above the word width take defined results. The block has no clock and no state. Result and carry follow the inputs in the same cycle.

Top module: `barrel_carry_shifter`

## Requirements
- R1: With kind code 2'b00 (left) and an effective amount n in 1..31, the result is the operand shifted left by n with zero fill, and carry out is operand bit 32-n.
- R2: A left shift by exactly 32 gives result 0 with carry out equal to operand bit 0; a left shift by more than 32 gives result 0 and carry out 0.
- R3: With kind code 2'b01 (logical right) and n in 1..31, the result is the operand shifted right by n with zero fill, and carry out is operand bit n-1.
- R4: A logical right shift by exactly 32 gives 0 with carry out equal to operand bit 31; by more than 32 it gives 0 with carry 0; an immediate amount of 0 (from_imm_in=1) is taken as 32.
- R5: With kind code 2'b10 (arithmetic right) the vacated bits take operand bit 31; for n in 1..31 carry out is operand bit n-1; for n of 32 or more, and for an immediate amount of 0, every result bit and the carry out equal operand bit 31.
- R6: With kind code 2'b11 (rotate right) the result is the operand rotated right by n mod 32 and carry out is result bit 31; a non-zero multiple of 32 leaves the operand unchanged with carry out equal to operand bit 31.
- R7: A rotate with an immediate amount of 0 shifts right by one through the carry: carry_in enters bit 31, and old bit 0 leaves as carry out.
- R8: A register amount (from_imm_in=0) of 0 passes the operand through unchanged with carry out equal to carry_in, for every kind.
- R9: A left shift with an immediate amount of 0 passes the operand through unchanged with carry out equal to carry_in.
- R10: An immediate amount uses only bits 4:0 of amt_in; bits 7:5 are ignored, so an immediate 0x24 acts as 4 and an immediate 0x20 acts as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_in | input | 32 | Operand to be shifted |
| amt_in | input | 8 | Shift amount; bits 4:0 when immediate, all 8 bits when from a register |
| kind_in | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 rotate right |
| from_imm_in | input | 1 | 1 when the amount comes from an instruction field, 0 from a register |
| carry_in | input | 1 | Incoming carry, used by pass-through and one-bit rotate |
| result_out | output | 32 | Shifted operand |
| carry_out | output | 1 | Last bit moved out of the word |

## Verification
The block has no state, so any fault shows at result_out and carry_out in the same cycle as the inputs that expose it. The faults that are easy to hide are the few points where the control selects a different path. One is a zero amount read the wrong way for one source or one kind. Another is a mistake at the 32 boundary, or a rotate mask that is off by one stage. Each of these corrupts only a narrow band of amounts, and often only the carry. For that reason the directed cases sit on amounts 0, 1, 31, 32, 33 and the non-zero multiples of 32, with the carry checked on each one. A wide sweep of random amounts and operands then covers the interior of the range.

// File: rtl/shf_pkg.sv
package shf_pkg;

  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;

  function automatic logic kind_is_left(input shift_kind_e k);
    return k == SK_LSL;
  endfunction

endpackage

// File: rtl/shf_amount_decode.sv
module shf_amount_decode
  import shf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int CNT_W    = $clog2(DATA_W)
) (
  input  shift_kind_e            kind,
  input  logic [REG_AMT_W-1:0]   amt_raw,
  input  logic                   from_imm,
  output logic                   pass_thru,
  output logic                   rrx,
  output logic                   full,
  output logic                   beyond,
  output logic [CNT_W-1:0]       low
);

  localparam logic [REG_AMT_W-1:0] WORD_AMT = REG_AMT_W'(DATA_W);

  logic [CNT_W-1:0]     imm_field;
  logic [REG_AMT_W-1:0] eff;

  always_comb begin
    imm_field = amt_raw[CNT_W-1:0];
    pass_thru = 1'b0;
    rrx       = 1'b0;
    eff       = '0;
    if (from_imm) begin
      if (imm_field == '0) begin
        unique case (kind)
          SK_LSL:         pass_thru = 1'b1;
          SK_LSR, SK_ASR: eff = WORD_AMT;
          SK_ROR:         rrx = 1'b1;
          default:        pass_thru = 1'b1;
        endcase
      end else begin
        eff = REG_AMT_W'(imm_field);
      end
    end else begin
      eff       = amt_raw;
      pass_thru = (amt_raw == '0);
    end
    full   = (eff == WORD_AMT);
    beyond = (eff > WORD_AMT);
    low    = eff[CNT_W-1:0];
  end

  always_comb begin
    p_zero_modes_excl_r8: assert ($onehot0({pass_thru, rrx, full, beyond}) || (!pass_thru && !rrx))
      else $error("zero-amount modes overlap");
    p_rrx_only_imm_ror_r7: assert (!rrx || (from_imm && kind == SK_ROR))
      else $error("rrx selected outside immediate rotate");
    p_imm_never_beyond_r4: assert (!(from_imm && beyond))
      else $error("immediate amount decoded above word width");
  end

endmodule

// File: rtl/shf_rotator.sv
module shf_rotator #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_in,
  input  logic [CNT_W-1:0]  rot_amt,
  output logic [DATA_W-1:0] data_out
);

  logic [DATA_W-1:0] stg [CNT_W+1];

  assign stg[0] = data_in;

  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stg[s+1] = rot_amt[s] ? {stg[s][K-1:0], stg[s][DATA_W-1:K]} : stg[s];
  end

  assign data_out = stg[CNT_W];

  always_comb begin
    p_rot_keeps_ones_r6: assert ($countones(data_out) == $countones(data_in))
      else $error("rotator lost or gained bits");
  end

endmodule

// File: rtl/shf_mask_gen.sv
module shf_mask_gen #(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic [CNT_W-1:0]  n,
  input  logic              left,
  output logic [DATA_W-1:0] keep
);

  localparam logic [DATA_W-1:0] ONES = {DATA_W{1'b1}};

  function automatic logic [DATA_W-1:0] keep_mask(input logic [CNT_W-1:0] k, input logic to_left);
    return to_left ? (ONES << k) : (ONES >> k);
  endfunction

  assign keep = keep_mask(n, left);

  always_comb begin
    p_mask_width_r3: assert ($countones(keep) == DATA_W - int'(n))
      else $error("mask width does not match shift amount");
  end

endmodule

// File: rtl/barrel_carry_shifter.sv
module barrel_carry_shifter
  import shf_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int REG_AMT_W = 8,
  localparam int CNT_W    = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]    op_in,
  input  logic [REG_AMT_W-1:0] amt_in,
  input  logic [1:0]           kind_in,
  input  logic                 from_imm_in,
  input  logic                 carry_in,
  output logic [DATA_W-1:0]    result_out,
  output logic                 carry_out
);

  shift_kind_e       kind;
  logic              pass_thru, rrx, full, beyond;
  logic [CNT_W-1:0]  low;
  logic [CNT_W-1:0]  rot_amt;
  logic [DATA_W-1:0] rotated;
  logic [DATA_W-1:0] keep;
  logic              is_left;
  logic              sign;

  assign kind    = shift_kind_e'(kind_in);
  assign is_left = kind_is_left(kind);
  assign sign    = op_in[DATA_W-1];
  assign rot_amt = is_left ? (CNT_W'(0) - low) : low;

  shf_amount_decode #(.DATA_W(DATA_W), .REG_AMT_W(REG_AMT_W)) u_decode (
    .kind      (kind),
    .amt_raw   (amt_in),
    .from_imm  (from_imm_in),
    .pass_thru (pass_thru),
    .rrx       (rrx),
    .full      (full),
    .beyond    (beyond),
    .low       (low)
  );

  shf_rotator #(.DATA_W(DATA_W)) u_rotator (
    .data_in  (op_in),
    .rot_amt  (rot_amt),
    .data_out (rotated)
  );

  shf_mask_gen #(.DATA_W(DATA_W)) u_mask (
    .n    (low),
    .left (is_left),
    .keep (keep)
  );

  always_comb begin
    result_out = op_in;
    carry_out  = carry_in;
    if (pass_thru) begin
      result_out = op_in;
      carry_out  = carry_in;
    end else if (rrx) begin
      result_out = {carry_in, op_in[DATA_W-1:1]};
      carry_out  = op_in[0];
    end else begin
      unique case (kind)
        SK_LSL: begin
          if (beyond) begin
            result_out = '0;
            carry_out  = 1'b0;
          end else if (full) begin
            result_out = '0;
            carry_out  = op_in[0];
          end else begin
            result_out = rotated & keep;
            carry_out  = rotated[0];
          end
        end
        SK_LSR: begin
          if (beyond) begin
            result_out = '0;
            carry_out  = 1'b0;
          end else if (full) begin
            result_out = '0;
            carry_out  = sign;
          end else begin
            result_out = rotated & keep;
            carry_out  = rotated[DATA_W-1];
          end
        end
        SK_ASR: begin
          if (beyond || full) begin
            result_out = {DATA_W{sign}};
            carry_out  = sign;
          end else begin
            result_out = (rotated & keep) | (~keep & {DATA_W{sign}});
            carry_out  = rotated[DATA_W-1];
          end
        end
        SK_ROR: begin
          if (low == '0) begin
            result_out = op_in;
            carry_out  = sign;
          end else begin
            result_out = rotated;
            carry_out  = rotated[DATA_W-1];
          end
        end
        default: begin
          result_out = op_in;
          carry_out  = carry_in;
        end
      endcase
    end
  end

  always_comb begin
    p_lsl_low_bit_clear_r1: assert (!(kind == SK_LSL && !pass_thru) || !result_out[0])
      else $error("left shift left bit 0 set");
    p_lsl_far_zero_r2: assert (!(kind == SK_LSL && beyond) || (result_out == '0 && !carry_out))
      else $error("left shift beyond width not cleared");
    p_lsr_top_clear_r3: assert (!(kind == SK_LSR && !pass_thru) || !result_out[DATA_W-1])
      else $error("logical right shift kept top bit");
    p_lsr_full_carry_r4: assert (!(kind == SK_LSR && full && !pass_thru) || carry_out == op_in[DATA_W-1])
      else $error("shift by width lost top bit in carry");
    p_asr_sign_kept_r5: assert (!(kind == SK_ASR && !pass_thru) || result_out[DATA_W-1] == op_in[DATA_W-1])
      else $error("arithmetic right shift changed sign");
    p_ror_carry_top_r6: assert (!(kind == SK_ROR && !pass_thru && !rrx) || carry_out == result_out[DATA_W-1])
      else $error("rotate carry differs from result top bit");
    p_rrx_body_r7: assert (!rrx || (result_out[DATA_W-2:0] == op_in[DATA_W-1:1] && carry_out == op_in[0]))
      else $error("one-bit rotate through carry wrong");
    p_pass_unchanged_r8: assert (!pass_thru || (result_out == op_in && carry_out == carry_in))
      else $error("zero amount altered operand or carry");
  end

endmodule

// File: tb/barrel_carry_shifter_bench.sv
module barrel_carry_shifter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_in = '0;
  logic [7:0]  amt_in = '0;
  logic [1:0]  kind_in = '0;
  logic        from_imm_in = 1'b0;
  logic        carry_in = 1'b0;
  logic [31:0] result_out;
  logic        carry_out;

  int checks = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  barrel_carry_shifter u_barrel_carry_shifter (
    .op_in       (op_in),
    .amt_in      (amt_in),
    .kind_in     (kind_in),
    .from_imm_in (from_imm_in),
    .carry_in    (carry_in),
    .result_out  (result_out),
    .carry_out   (carry_out)
  );

  // Behavioural model built on wide shifts, independent of the rotator design.
  function automatic logic [32:0] model(input logic [31:0] op, input logic [7:0] amt,
                                        input logic [1:0] kind, input logic imm, input logic cin);
    int n;
    logic [63:0] t;
    logic signed [63:0] st;
    n = imm ? int'(amt[4:0]) : int'(amt);
    if (n == 0 && (!imm || kind == 2'b00)) return {cin, op};
    if (n == 0 && imm && kind == 2'b11) return {op[0], cin, op[31:1]};
    if (n == 0) n = 32;
    case (kind)
      2'b00: begin
        t = {32'b0, op} << n;
        return {t[32], t[31:0]};
      end
      2'b01: begin
        t = {op, 32'b0} >> n;
        return {t[31], t[63:32]};
      end
      2'b10: begin
        if (n >= 32) return {op[31], {32{op[31]}}};
        st = $signed({op, 32'b0}) >>> n;
        return {st[31], st[63:32]};
      end
      default: begin
        if (n % 32 == 0) return {op[31], op};
        t = {op, op} >> (n % 32);
        return {t[31], t[31:0]};
      end
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] amt, input logic [1:0] kind, input logic imm);
    int n;
    n = imm ? int'(amt[4:0]) : int'(amt);
    if (imm && amt[7:5] != 0) return "R10";
    if (n == 0 && !imm) return "R8";
    if (n == 0 && kind == 2'b00) return "R9";
    if (n == 0 && kind == 2'b11) return "R7";
    case (kind)
      2'b00: return (n >= 32) ? "R2" : "R1";
      2'b01: return (n >= 32 || n == 0) ? "R4" : "R3";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic apply(input logic [31:0] op, input logic [7:0] amt, input logic [1:0] kind,
                       input logic imm, input logic cin, input logic [31:0] exp_res,
                       input logic exp_c, input string req);
    @(posedge clk);
    op_in = op; amt_in = amt; kind_in = kind; from_imm_in = imm; carry_in = cin;
    @(negedge clk);
    checks++;
    if (result_out !== exp_res || carry_out !== exp_c) begin
      bad++;
      $display("FAIL %s: op=%h amt=%h kind=%0d imm=%0b cin=%0b actual=%h/%0b expected=%h/%0b",
               req, op, amt, kind, imm, cin, result_out, carry_out, exp_res, exp_c);
    end
  endtask

  task automatic apply_model(input logic [31:0] op, input logic [7:0] amt, input logic [1:0] kind,
                             input logic imm, input logic cin);
    logic [32:0] e;
    e = model(op, amt, kind, imm, cin);
    apply(op, amt, kind, imm, cin, e[31:0], e[32], tag_of(amt, kind, imm));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle inputs after reset: zero operand passes through (R8)
    apply(32'h0, 8'd0, 2'b00, 1'b0, 1'b0, 32'h0, 1'b0, "R8");

    apply(32'h8000_0000, 8'd1,  2'b00, 1'b0, 1'b0, 32'h0000_0000, 1'b1, "R1");
    apply(32'h0000_4001, 8'd18, 2'b00, 1'b0, 1'b0, 32'h0004_0000, 1'b1, "R1");
    apply(32'h0000_4001, 8'd17, 2'b00, 1'b1, 1'b1, 32'h8002_0000, 1'b0, "R1");
    apply(32'h0000_0001, 8'd32, 2'b00, 1'b0, 1'b0, 32'h0000_0000, 1'b1, "R2");
    apply(32'hFFFF_FFFF, 8'd33, 2'b00, 1'b0, 1'b1, 32'h0000_0000, 1'b0, "R2");

    apply(32'h1234_5678, 8'd4,  2'b01, 1'b0, 1'b0, 32'h0123_4567, 1'b1, "R3");
    apply(32'h0123_4567, 8'd4,  2'b01, 1'b1, 1'b1, 32'h0012_3456, 1'b0, "R3");
    apply(32'h0800_3001, 8'd1,  2'b01, 1'b0, 1'b0, 32'h0400_1800, 1'b1, "R3");
    apply(32'hFFFF_FFFF, 8'd32, 2'b01, 1'b0, 1'b0, 32'h0, 1'b1, "R4");
    apply(32'h7FFF_FFFF, 8'd32, 2'b01, 1'b0, 1'b1, 32'h0, 1'b0, "R4");
    apply(32'hFFFF_FFFF, 8'd33, 2'b01, 1'b0, 1'b0, 32'h0, 1'b0, "R4");
    apply(32'hFFFF_FFFF, 8'd0,  2'b01, 1'b1, 1'b0, 32'h0, 1'b1, "R4");

    apply(32'h8000_0030, 8'd1,  2'b10, 1'b0, 1'b0, 32'hC000_0018, 1'b0, "R5");
    apply(32'hFFFF_0000, 8'd11, 2'b10, 1'b0, 1'b0, 32'hFFFF_FFE0, 1'b0, "R5");
    apply(32'hFFC0_0000, 8'd23, 2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, "R5");
    apply(32'h8000_0000, 8'd32, 2'b10, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, "R5");
    apply(32'h8000_0000, 8'd0,  2'b10, 1'b1, 1'b0, 32'hFFFF_FFFF, 1'b1, "R5");
    apply(32'h7000_0000, 8'd200,2'b10, 1'b0, 1'b1, 32'h0000_0000, 1'b0, "R5");
    apply(32'h0123_0031, 8'd3,  2'b10, 1'b0, 1'b0, 32'h0024_6006, 1'b0, "R5");

    apply(32'hABCD_1234, 8'd4,  2'b11, 1'b0, 1'b0, 32'h4ABC_D123, 1'b0, "R6");
    apply(32'hA5F9_6342, 8'd17, 2'b11, 1'b1, 1'b0, 32'hB1A1_52FC, 1'b1, "R6");
    apply(32'h385F_7DCE, 8'd32, 2'b11, 1'b0, 1'b1, 32'h385F_7DCE, 1'b0, "R6");
    apply(32'hFECD_BA12, 8'd32, 2'b11, 1'b0, 1'b0, 32'hFECD_BA12, 1'b1, "R6");
    apply(32'hABCD_1234, 8'd36, 2'b11, 1'b0, 1'b0, 32'h4ABC_D123, 1'b0, "R6");
    apply(32'hFECD_BA12, 8'd64, 2'b11, 1'b0, 1'b0, 32'hFECD_BA12, 1'b1, "R6");

    apply(32'h123F_ABCF, 8'd0,  2'b11, 1'b1, 1'b0, 32'h091F_D5E7, 1'b1, "R7");
    apply(32'h123F_ABCE, 8'd0,  2'b11, 1'b1, 1'b1, 32'h891F_D5E7, 1'b0, "R7");

    apply(32'h8000_0001, 8'd0,  2'b10, 1'b0, 1'b1, 32'h8000_0001, 1'b1, "R8");
    apply(32'h8000_0001, 8'd0,  2'b11, 1'b0, 1'b0, 32'h8000_0001, 1'b0, "R8");
    apply(32'hFFFF_FFFF, 8'd0,  2'b01, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b1, "R8");
    apply(32'hDEAD_BEEF, 8'd0,  2'b00, 1'b1, 1'b1, 32'hDEAD_BEEF, 1'b1, "R9");
    apply(32'hDEAD_BEEF, 8'd0,  2'b00, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b0, "R9");

    apply(32'h1234_5678, 8'h24, 2'b01, 1'b1, 1'b0, 32'h0123_4567, 1'b1, "R10");
    apply(32'h1234_5678, 8'h20, 2'b01, 1'b1, 1'b1, 32'h0000_0000, 1'b0, "R10");
    apply(32'h0000_4001, 8'hF2, 2'b00, 1'b1, 1'b0, 32'h0004_0000, 1'b1, "R10");

    // Broad sweep against the behavioural model
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = (i % 3 == 0) ? 8'($urandom) : 8'($urandom % 70);
      apply_model($urandom, a, 2'($urandom), 1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule